// File: doc/BRIEF.md
# Converter-to-System Sample Buffer with Overflow Guard

This block sits between a sample-producing converter, running on its own sample clock, and the system clock domain. Each sample the converter strobes in is written into a 64-entry elastic store. The oldest unread entry is carried across to the system clock and shown in a presentation register, together with a valid flag.

The entry is consumed by one of two readers. One is an autonomous transfer engine that moves samples to memory. The other is the CPU, which reads the presentation register directly. A mode input picks the reader, and the strobe from the other reader is ignored.

When 64 samples are waiting unread, the buffer is full. Any later sample is thrown away, so stored entries are never overwritten, and a sticky overflow flag is raised. Software clears that flag with a write-one-to-clear strobe. After the converter stops, the entries still stored stay readable, and the CPU can keep reading until the empty status comes on. The system clock must run at least as fast as the sample rate, or overflow is expected.

Top module: `sbuf_out_buffer`

## Requirements
- R1: While rst_ni is low and right after it rises, empty_o=1, full_o=0, ovf_o=0 and data_valid_o=0.
- R2: Samples appear on data_o in the order they arrived. data_valid_o=1 marks a presented sample, and it drops in the cycle after that sample is consumed.
- R3: The buffer holds exactly 64 unread samples, counting the one in the presentation register. With 64 unread, full_o=1, and all 64 later read out intact.
- R4: A sample strobed while the buffer is full is discarded, stored entries are not overwritten, and ovf_o rises within a few system clocks.
- R5: ovf_o stays at 1 until a pulse on ovf_clr_i, which returns it to 0. A new discard in the same cycle wins over the clear.
- R6: With mode_cpu_i=1, a cpu_rd_i pulse consumes the presented sample and xfer_take_i is ignored. With mode_cpu_i=0, xfer_take_i consumes and cpu_rd_i is ignored.
- R7: A read strobe while data_valid_o=0 has no effect: the next sample presented is still the oldest unread one.
- R8: After samples stop arriving, every remaining entry can still be read. empty_o=1 exactly when no unread sample remains, and full_o returns to 0.
- R9: Operation continues correctly across pointer wrap-around, for more than 128 samples in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| smp_clk_i | input | 1 | Converter sample clock |
| smp_valid_i | input | 1 | New sample strobe (sample clock) |
| smp_data_i | input | DATA_W | Sample word |
| sys_clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| mode_cpu_i | input | 1 | 1: CPU is the reader, 0: transfer engine is the reader |
| xfer_take_i | input | 1 | Transfer engine consume strobe |
| cpu_rd_i | input | 1 | CPU read strobe for the presentation register |
| ovf_clr_i | input | 1 | Write-one-to-clear strobe for the overflow flag |
| data_o | output | DATA_W | Presentation register |
| data_valid_o | output | 1 | Presentation register holds an unread sample |
| empty_o | output | 1 | No unread samples remain |
| full_o | output | 1 | 64 unread samples are stored |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench fills the buffer to exactly 64 entries and then strobes more samples in. A design that overwrote entries, or that counted the presentation register as extra space, would return the wrong sequence or the wrong count when drained. It checks that the strobe of the reader not selected, and any strobe sent while nothing is presented, leave the next sample unchanged. A design that popped on those strobes would lose samples. It streams more than twice the depth without pauses to reach pointer wrap-around, where a bad Gray compare shows up as a false full or a false empty. It also checks that the overflow flag survives until its clear strobe and that empty asserts only after the very last read.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int unsigned SBUF_DATA_W     = 16;
  localparam int unsigned SBUF_DEPTH_LOG2 = 6;
endpackage

// File: rtl/sbuf_sync.sv
module sbuf_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sbuf_mem.sv
module sbuf_mem #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned AW     = 6
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // Entry is stable: pointer crossing lags the write by two sync stages
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sbuf_wr_ctrl.sv
module sbuf_wr_ctrl #(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_valid_i,
  input  logic [AW:0]   rgray_sync_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic          ovf_tgl_o
);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0] wbin_q, wbin_d;
  logic [PW-1:0] wgray_q;
  logic          full_w;
  logic          push, drop;
  logic          ovf_tgl_q;

  assign full_w = (wgray_q == {~rgray_sync_i[PW-1:PW-2], rgray_sync_i[PW-3:0]});
  assign push   = smp_valid_i && !full_w;
  assign drop   = smp_valid_i && full_w;
  assign wbin_d = wbin_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q    <= '0;
      wgray_q   <= '0;
      ovf_tgl_q <= 1'b0;
    end else begin
      if (push) begin
        wbin_q  <= wbin_d;
        wgray_q <= wbin_d ^ (wbin_d >> 1);
      end
      if (drop) ovf_tgl_q <= ~ovf_tgl_q;
    end
  end

  assign we_o      = push;
  assign waddr_o   = wbin_q[AW-1:0];
  assign wgray_o   = wgray_q;
  assign ovf_tgl_o = ovf_tgl_q;

  // R4: a discarded sample never advances the write pointer
  a_r4_drop_keeps_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && full_w) |=> $stable(wgray_q));

  // R3: Gray pointer moves one bit per accepted sample
  a_r3_gray_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |=> ($countones(wgray_q ^ $past(wgray_q)) == 1));
endmodule

// File: rtl/sbuf_rd_ctrl.sv
module sbuf_rd_ctrl #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned AW     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW:0]       wgray_sync_i,
  input  logic              ovf_tgl_sync_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              mode_cpu_i,
  input  logic              xfer_take_i,
  input  logic              cpu_rd_i,
  input  logic              ovf_clr_i,
  output logic [AW-1:0]     raddr_o,
  output logic [AW:0]       rgray_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_valid_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ovf_o
);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0]     rbin_q, rbin_d;
  logic [PW-1:0]     rgray_q;
  logic [DATA_W-1:0] hold_q;
  logic              valid_q;
  logic              consume;
  logic              empty_r;
  logic              tgl_seen_q;
  logic              ovf_evt;
  logic              ovf_q;

  assign empty_r = (rgray_q == wgray_sync_i);
  assign consume = valid_q && (mode_cpu_i ? cpu_rd_i : xfer_take_i);
  assign rbin_d  = rbin_q + PW'(1);

  // Presentation register mirrors the head; the pointer only moves on consume
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      hold_q  <= '0;
      valid_q <= 1'b0;
    end else if (consume) begin
      rbin_q  <= rbin_d;
      rgray_q <= rbin_d ^ (rbin_d >> 1);
      valid_q <= 1'b0;
    end else if (!valid_q && !empty_r) begin
      hold_q  <= rdata_i;
      valid_q <= 1'b1;
    end
  end

  assign ovf_evt = ovf_tgl_sync_i ^ tgl_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_seen_q <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      tgl_seen_q <= ovf_tgl_sync_i;
      if (ovf_evt)        ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  assign raddr_o      = rbin_q[AW-1:0];
  assign rgray_o      = rgray_q;
  assign data_o       = hold_q;
  assign data_valid_o = valid_q;
  assign empty_o      = empty_r;
  assign full_o       = (wgray_sync_i == {~rgray_q[PW-1:PW-2], rgray_q[PW-3:0]});
  assign ovf_o        = ovf_q;

  // R2: a consumed sample is withdrawn in the next cycle
  a_r2_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume |=> !valid_q);

  // R7: strobes with nothing presented leave the read pointer alone
  a_r7_idle_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |=> $stable(rgray_q));

  // R5: overflow flag holds until cleared
  a_r5_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr_i) |=> ovf_q);

  // R8: nothing is presented from an empty buffer
  a_r8_no_phantom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_r && !valid_q) |=> !valid_q);

  // R3: full and empty are exclusive
  a_r3_full_xor_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_r));

  // R6: the strobe of the reader not selected is ignored
  a_r6_wrong_reader: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && (mode_cpu_i ? !cpu_rd_i : !xfer_take_i)) |=> valid_q);
endmodule

// File: rtl/sbuf_out_buffer.sv
module sbuf_out_buffer
  import sbuf_pkg::*;
#(
  parameter int unsigned DATA_W     = SBUF_DATA_W,
  parameter int unsigned DEPTH_LOG2 = SBUF_DEPTH_LOG2
) (
  input  logic              smp_clk_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic              sys_clk_i,
  input  logic              rst_ni,
  input  logic              mode_cpu_i,
  input  logic              xfer_take_i,
  input  logic              cpu_rd_i,
  input  logic              ovf_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_valid_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ovf_o
);
  localparam int unsigned AW = DEPTH_LOG2;
  localparam int unsigned PW = AW + 1;

  logic              we;
  logic [AW-1:0]     waddr, raddr;
  logic [DATA_W-1:0] rdata;
  logic [PW-1:0]     wgray, rgray, wgray_sync, rgray_sync;
  logic              ovf_tgl, ovf_tgl_sync;

  sbuf_mem #(.DATA_W(DATA_W), .AW(AW)) i_mem (
    .wclk_i (smp_clk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(smp_data_i),
    .raddr_i(raddr),
    .rdata_o(rdata)
  );

  sbuf_wr_ctrl #(.AW(AW)) i_wr (
    .clk_i       (smp_clk_i),
    .rst_ni      (rst_ni),
    .smp_valid_i (smp_valid_i),
    .rgray_sync_i(rgray_sync),
    .we_o        (we),
    .waddr_o     (waddr),
    .wgray_o     (wgray),
    .ovf_tgl_o   (ovf_tgl)
  );

  sbuf_sync #(.WIDTH(PW), .STAGES(2)) i_sync_r2w (
    .clk_i (smp_clk_i),
    .rst_ni(rst_ni),
    .d_i   (rgray),
    .q_o   (rgray_sync)
  );

  sbuf_sync #(.WIDTH(PW), .STAGES(2)) i_sync_w2r (
    .clk_i (sys_clk_i),
    .rst_ni(rst_ni),
    .d_i   (wgray),
    .q_o   (wgray_sync)
  );

  sbuf_sync #(.WIDTH(1), .STAGES(2)) i_sync_ovf (
    .clk_i (sys_clk_i),
    .rst_ni(rst_ni),
    .d_i   (ovf_tgl),
    .q_o   (ovf_tgl_sync)
  );

  sbuf_rd_ctrl #(.DATA_W(DATA_W), .AW(AW)) i_rd (
    .clk_i         (sys_clk_i),
    .rst_ni        (rst_ni),
    .wgray_sync_i  (wgray_sync),
    .ovf_tgl_sync_i(ovf_tgl_sync),
    .rdata_i       (rdata),
    .mode_cpu_i    (mode_cpu_i),
    .xfer_take_i   (xfer_take_i),
    .cpu_rd_i      (cpu_rd_i),
    .ovf_clr_i     (ovf_clr_i),
    .raddr_o       (raddr),
    .rgray_o       (rgray),
    .data_o        (data_o),
    .data_valid_o  (data_valid_o),
    .empty_o       (empty_o),
    .full_o        (full_o),
    .ovf_o         (ovf_o)
  );
endmodule

// File: tb/test_sbuf_out_buffer.sv
`timescale 1ns/1ps
module test_sbuf_out_buffer;
  localparam int DW = 16;

  logic          sys_clk = 1'b0, smp_clk = 1'b0, rst_n = 1'b0;
  logic          smp_valid = 1'b0, mode_cpu = 1'b1;
  logic          xfer_take = 1'b0, cpu_rd = 1'b0, ovf_clr = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic [DW-1:0] data;
  logic          data_valid, empty, full, ovf;

  int tests = 0, fails = 0;
  bit auto_drain = 1'b0;
  bit done = 1'b0;
  logic [DW-1:0] sb_q [$];

  always #2 sys_clk = ~sys_clk;
  always #5 smp_clk = ~smp_clk;

  sbuf_out_buffer i_sbuf_out_buffer (
    .smp_clk_i   (smp_clk),
    .smp_valid_i (smp_valid),
    .smp_data_i  (smp_data),
    .sys_clk_i   (sys_clk),
    .rst_ni      (rst_n),
    .mode_cpu_i  (mode_cpu),
    .xfer_take_i (xfer_take),
    .cpu_rd_i    (cpu_rd),
    .ovf_clr_i   (ovf_clr),
    .data_o      (data),
    .data_valid_o(data_valid),
    .empty_o     (empty),
    .full_o      (full),
    .ovf_o       (ovf)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: pushes the expected item when the sample should be kept
  task automatic push(input logic [DW-1:0] d, input bit keep);
    @(negedge smp_clk);
    smp_valid = 1'b1;
    smp_data  = d;
    if (keep) sb_q.push_back(d);
    @(negedge smp_clk);
    smp_valid = 1'b0;
  endtask

  task automatic take_pulse(input bit use_cpu);
    @(negedge sys_clk);
    if (use_cpu) cpu_rd = 1'b1; else xfer_take = 1'b1;
    @(negedge sys_clk);
    cpu_rd = 1'b0;
    xfer_take = 1'b0;
  endtask

  task automatic wait_drained();
    while (sb_q.size() != 0) @(negedge sys_clk);
    repeat (6) @(negedge sys_clk);
  endtask

  // Monitor: compares each presented sample with the scoreboard (R2, R9)
  initial begin
    forever begin
      @(negedge sys_clk);
      if (auto_drain && data_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R2 unexpected sample", 32'(data), 32'hx);
        end else begin
          logic [DW-1:0] e;
          e = sb_q.pop_front();
          check(data == e, "R2/R9 sample order", 32'(data), 32'(e));
        end
        if (mode_cpu) cpu_rd = 1'b1; else xfer_take = 1'b1;
        @(negedge sys_clk);
        cpu_rd = 1'b0;
        xfer_take = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge sys_clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge sys_clk);
    check(empty == 1'b1, "R1 empty in reset", 32'(empty), 1);
    check(data_valid == 1'b0, "R1 valid in reset", 32'(data_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge sys_clk);
    check(empty == 1'b1 && full == 1'b0, "R1 empty/full after reset", {empty, full}, 2'b10);
    check(ovf == 1'b0 && data_valid == 1'b0, "R1 ovf/valid after reset", {ovf, data_valid}, 0);

    // R7: strobes with nothing presented
    take_pulse(1'b1);
    take_pulse(1'b1);
    push(16'h1234, 1'b0);
    repeat (8) @(negedge sys_clk);
    check(data_valid && data == 16'h1234, "R7 first sample after idle strobes", 32'(data), 32'h1234);
    take_pulse(1'b1);
    repeat (3) @(negedge sys_clk);
    check(empty == 1'b1 && data_valid == 1'b0, "R8 empty after single read", {empty, data_valid}, 2'b10);

    // R2 CPU mode, varied patterns
    mode_cpu = 1'b1;
    auto_drain = 1'b1;
    push(16'h0000, 1'b1);
    push(16'hFFFF, 1'b1);
    push(16'hA5A5, 1'b1);
    push(16'h5A5A, 1'b1);
    for (int i = 0; i < 8; i++) push(DW'(16'h0001 << i), 1'b1);
    wait_drained();
    check(empty == 1'b1, "R8 empty after CPU stream", 32'(empty), 1);

    // R6 controller mode stream
    mode_cpu = 1'b0;
    for (int i = 0; i < 10; i++) push(DW'(16'h3000 + i * 7), 1'b1);
    wait_drained();

    // R6: wrong reader's strobe ignored, in both modes
    auto_drain = 1'b0;
    push(16'hBEEF, 1'b0);
    push(16'hCAFE, 1'b0);
    repeat (8) @(negedge sys_clk);
    take_pulse(1'b1);
    repeat (3) @(negedge sys_clk);
    check(data_valid && data == 16'hBEEF, "R6 cpu_rd ignored in controller mode", 32'(data), 32'hBEEF);
    take_pulse(1'b0);
    repeat (3) @(negedge sys_clk);
    check(data_valid && data == 16'hCAFE, "R6 xfer_take consumes in controller mode", 32'(data), 32'hCAFE);
    mode_cpu = 1'b1;
    take_pulse(1'b0);
    repeat (3) @(negedge sys_clk);
    check(data_valid && data == 16'hCAFE, "R6 xfer_take ignored in CPU mode", 32'(data), 32'hCAFE);
    take_pulse(1'b1);
    repeat (3) @(negedge sys_clk);
    check(empty == 1'b1 && data_valid == 1'b0, "R6 cpu_rd consumes in CPU mode", {empty, data_valid}, 2'b10);

    // R3/R4/R5: fill to 64 then overrun
    for (int i = 0; i < 64; i++) push(DW'(16'h8000 + i), 1'b1);
    repeat (10) @(negedge sys_clk);
    check(full == 1'b1, "R3 full at 64 unread", 32'(full), 1);
    check(ovf == 1'b0, "R3 no overflow at exactly 64", 32'(ovf), 0);
    push(16'hDEAD, 1'b0);
    push(16'hDEAD, 1'b0);
    push(16'hDEAD, 1'b0);
    repeat (10) @(negedge sys_clk);
    check(ovf == 1'b1, "R4 overflow on discarded sample", 32'(ovf), 1);
    check(full == 1'b1, "R4 still full after discard", 32'(full), 1);
    check(data == 16'h8000, "R4 head not overwritten", 32'(data), 32'h8000);
    repeat (20) @(negedge sys_clk);
    check(ovf == 1'b1, "R5 overflow sticky", 32'(ovf), 1);
    @(negedge sys_clk);
    ovf_clr = 1'b1;
    @(negedge sys_clk);
    ovf_clr = 1'b0;
    repeat (2) @(negedge sys_clk);
    check(ovf == 1'b0, "R5 overflow cleared", 32'(ovf), 0);

    // R8: converter stopped, CPU drains the remainder
    auto_drain = 1'b1;
    wait_drained();
    check(empty == 1'b1, "R8 empty after drain", 32'(empty), 1);
    check(full == 1'b0, "R8 not full after drain", 32'(full), 0);
    check(data_valid == 1'b0, "R8 nothing presented after drain", 32'(data_valid), 0);

    // R9: long back-to-back stream across pointer wrap
    mode_cpu = 1'b0;
    for (int i = 0; i < 150; i++) push(DW'(i * 16'h0107 + 16'h0011), 1'b1);
    wait_drained();
    check(empty == 1'b1 && ovf == 1'b0, "R9 clean after wrap stream", {empty, ovf}, 2'b10);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule